// File: doc/BRIEF.md
# Switch Reset and Boot Configuration Sequencer

This block brings an attached Ethernet switch device out of reset and loads its boot configuration. A start request arms the sequence. If the board has a reset line for the switch, the block drives that line through a timed high, low, high waveform. Millisecond timing comes from a prescaled counter. Strap levels go on the serial clock and data pins just before the line returns high. The block then releases those pins to high impedance and keeps the reset line driven high.

After the waveform, or at once when the board has no reset line, the block issues two fixed register writes to a serial register master. It uses a valid/ready command channel and waits for a done pulse after each write. The first write sets the CPU-facing port register and the second sets the mode register that turns on VLAN operation. A one-cycle completion pulse ends the run. The serial bit protocol belongs to the register master and is not part of this block.

The command channel obeys back-pressure. `cmd_valid` stays high with address and data unchanged until a rising clock edge where `cmd_ready` is also high, and one write transfers at that edge. `cmd_ready` may stay low for any number of cycles.

Top module: `switch_boot_seq`

## Requirements
- R1: After reset `busy`, `done` and `cmd_valid` are low and the output enables `rc_oe`, `cs_oe`, `sk_oe` and `di_oe` are all low.
- R2: A `start` sampled in idle with `rst_pin_en` high drives the reset line high (`rc_oe`=1, `rc_o`=1) from the next cycle, with clock and data pins not driven, for T_PRE_MS*CLK_PER_MS cycles.
- R3: The reset line is then driven low for T_LOW_MS*CLK_PER_MS cycles plus one strap setup cycle.
- R4: The strap levels (`sk_oe`=1, `sk_o`=1, `di_oe`=1, `di_o`=0) appear in only the final low cycle before the line rises, and they stay in place while the line is high.
- R5: The line is held high with straps for T_POST_MS*CLK_PER_MS cycles. Clock and data are then released (enables 0) while `rc_oe` and `rc_o` stay 1, including after the run. `cs_oe` is never asserted.
- R6: Two writes follow, in this order: address 0x09 with data 0xBC1F, then address 0x11 with data 0xFF30. The first sets bit 15 (auto crossover), default VLAN 15 in bits 13:10, bit 4 (tagging) and bits 3:0 (autonegotiation, 100 Mb/s, full duplex, flow control). The second enables VLAN mode. Clock and data are not driven while a command is offered.
- R7: While `cmd_valid` is high and `cmd_ready` low, `cmd_valid`, `cmd_addr` and `cmd_data` hold. After a transfer edge `cmd_valid` is low in the next cycle.
- R8: No new command is offered until `wr_done` is seen for the previous one. A `wr_done` pulse while a command is still being offered has no effect.
- R9: `done` is high for exactly the one cycle after the edge that samples `wr_done` for the last write. `busy` is high from the cycle after `start` through that cycle and low afterwards.
- R10: A `start` sampled with `rst_pin_en` low skips the waveform. `rc_oe`, `sk_oe` and `di_oe` stay low, and `cmd_valid` rises in the cycle after `start`.
- R11: A `start` while `busy` is high is ignored. Phase lengths and the write count are unchanged, and no new run follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled in idle only |
| rst_pin_en | input | 1 | Board has a switch reset line |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rc_oe | output | 1 | Reset line output enable |
| rc_o | output | 1 | Reset line level |
| cs_oe | output | 1 | Chip select output enable (kept released) |
| cs_o | output | 1 | Chip select level |
| sk_oe | output | 1 | Serial clock pin output enable (strap) |
| sk_o | output | 1 | Serial clock pin level |
| di_oe | output | 1 | Serial data pin output enable (strap) |
| di_o | output | 1 | Serial data pin level |
| cmd_valid | output | 1 | Write command offered |
| cmd_ready | input | 1 | Register master accepts the command |
| cmd_addr | output | 8 | Register address of the command |
| cmd_data | output | 16 | Register value of the command |
| wr_done | input | 1 | Register master finished the accepted write |

## Verification
The bench builds the block with CLK_PER_MS at 10 and the default 20/100/30 ms phases. The whole waveform then fits in about 1,500 cycles, so every phase can be counted cycle by cycle against its exact length. The register master model runs once with `cmd_ready` always high and once with it high only every third cycle. Together these cover the held command under back-pressure, a stray `wr_done` during an offer, and done latencies of one and four cycles. Runs with and without the reset line, plus start requests during the waveform and during the writes, cover the skip path and the ignored requests.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_HI,
    ST_RST_LO,
    ST_STRAP,
    ST_POST_HI,
    ST_WRITES,
    ST_FIN
  } seq_state_t;

  typedef enum logic [1:0] {
    WS_REQ,
    WS_WAIT,
    WS_END
  } wr_state_t;

  typedef struct packed {
    logic [7:0]  addr;
    logic [15:0] data;
  } boot_wr_t;

  typedef struct packed {
    logic rc_oe;
    logic rc_o;
    logic cs_oe;
    logic cs_o;
    logic sk_oe;
    logic sk_o;
    logic di_oe;
    logic di_o;
  } pin_drv_t;

  localparam int NUM_BOOT_WR = 2;

endpackage

// File: rtl/swb_ms_timer.sv
module swb_ms_timer #(
  parameter int CLK_PER_MS = 1000,
  parameter int MS_W       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MS_W-1:0] load_ms,
  output logic            expire
);
  localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;
  logic             run_q;
  logic             pre_last;

  assign pre_last = (pre_q == PRE_LAST);
  assign expire   = run_q && pre_last && (ms_q == MS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      pre_q <= '0;
      ms_q  <= load_ms;
      run_q <= (load_ms != '0);
    end else if (run_q) begin
      if (pre_last) begin
        pre_q <= '0;
        ms_q  <= ms_q - MS_W'(1);
        if (ms_q == MS_W'(1)) run_q <= 1'b0;
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/swb_pin_map.sv
module swb_pin_map
  import swb_pkg::*;
#(
  parameter bit SK_STRAP = 1'b1,
  parameter bit DI_STRAP = 1'b0
) (
  input  seq_state_t state,
  input  logic       rc_owned,
  output pin_drv_t   pins
);
  always_comb begin
    pins       = '0;
    pins.rc_o  = 1'b1;
    pins.rc_oe = rc_owned;
    unique case (state)
      ST_PRE_HI: begin
        pins.rc_oe = 1'b1;
        pins.rc_o  = 1'b1;
      end
      ST_RST_LO: begin
        pins.rc_oe = 1'b1;
        pins.rc_o  = 1'b0;
      end
      ST_STRAP: begin
        pins.rc_oe = 1'b1;
        pins.rc_o  = 1'b0;
        pins.sk_oe = 1'b1;
        pins.sk_o  = SK_STRAP;
        pins.di_oe = 1'b1;
        pins.di_o  = DI_STRAP;
      end
      ST_POST_HI: begin
        pins.rc_oe = 1'b1;
        pins.rc_o  = 1'b1;
        pins.sk_oe = 1'b1;
        pins.sk_o  = SK_STRAP;
        pins.di_oe = 1'b1;
        pins.di_o  = DI_STRAP;
      end
      default: begin
        pins.rc_oe = rc_owned;
        pins.rc_o  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/swb_wr_issue.sv
module swb_wr_issue
  import swb_pkg::*;
#(
  parameter int NUM = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  boot_wr_t [NUM-1:0]       wr_list,
  input  logic                     cmd_ready,
  input  logic                     wr_done,
  output logic                     cmd_valid,
  output logic [7:0]               cmd_addr,
  output logic [15:0]              cmd_data,
  output logic                     fin
);
  localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM - 1);

  wr_state_t        ws_q;
  logic [IDX_W-1:0] idx_q;
  boot_wr_t         cur;

  assign cur       = wr_list[idx_q];
  assign cmd_valid = en && (ws_q == WS_REQ);
  assign cmd_addr  = cur.addr;
  assign cmd_data  = cur.data;
  assign fin       = en && (ws_q == WS_WAIT) && wr_done && (idx_q == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q  <= WS_REQ;
      idx_q <= '0;
    end else if (!en) begin
      ws_q  <= WS_REQ;
      idx_q <= '0;
    end else begin
      unique case (ws_q)
        WS_REQ:  if (cmd_ready) ws_q <= WS_WAIT;
        WS_WAIT: if (wr_done) begin
          if (idx_q == IDX_LAST) begin
            ws_q <= WS_END;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
            ws_q  <= WS_REQ;
          end
        end
        default: ws_q <= WS_END;
      endcase
    end
  end
endmodule

// File: rtl/switch_boot_seq.sv
module switch_boot_seq
  import swb_pkg::*;
#(
  parameter int          CLK_PER_MS    = 50000,
  parameter int          T_PRE_MS      = 20,
  parameter int          T_LOW_MS      = 100,
  parameter int          T_POST_MS     = 30,
  parameter logic [7:0]  PORT_REG_ADDR = 8'h09,
  parameter logic [15:0] PORT_REG_VAL  = 16'hBC1F,
  parameter logic [7:0]  MODE_REG_ADDR = 8'h11,
  parameter logic [15:0] MODE_REG_VAL  = 16'hFF30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rst_pin_en,
  output logic        busy,
  output logic        done,
  output logic        rc_oe,
  output logic        rc_o,
  output logic        cs_oe,
  output logic        cs_o,
  output logic        sk_oe,
  output logic        sk_o,
  output logic        di_oe,
  output logic        di_o,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [7:0]  cmd_addr,
  output logic [15:0] cmd_data,
  input  logic        wr_done
);
  localparam int T_MAX_A = (T_PRE_MS > T_LOW_MS) ? T_PRE_MS : T_LOW_MS;
  localparam int T_MAX   = (T_MAX_A > T_POST_MS) ? T_MAX_A : T_POST_MS;
  localparam int MS_W    = $clog2(T_MAX + 1);

  seq_state_t                 st_q, st_d;
  logic                       tmr_load;
  logic [MS_W-1:0]            tmr_ms;
  logic                       tmr_exp;
  logic                       rc_own_q;
  logic                       wr_fin;
  logic                       wr_en;
  pin_drv_t                   pins;
  boot_wr_t [NUM_BOOT_WR-1:0] boot_list;

  assign boot_list[0] = '{addr: PORT_REG_ADDR, data: PORT_REG_VAL};
  assign boot_list[1] = '{addr: MODE_REG_ADDR, data: MODE_REG_VAL};

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_ms   = '0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        if (rst_pin_en) begin
          st_d     = ST_PRE_HI;
          tmr_load = 1'b1;
          tmr_ms   = MS_W'(T_PRE_MS);
        end else begin
          st_d = ST_WRITES;
        end
      end
      ST_PRE_HI: if (tmr_exp) begin
        st_d     = ST_RST_LO;
        tmr_load = 1'b1;
        tmr_ms   = MS_W'(T_LOW_MS);
      end
      ST_RST_LO: if (tmr_exp) st_d = ST_STRAP;
      ST_STRAP: begin
        st_d     = ST_POST_HI;
        tmr_load = 1'b1;
        tmr_ms   = MS_W'(T_POST_MS);
      end
      ST_POST_HI: if (tmr_exp) st_d = ST_WRITES;
      ST_WRITES:  if (wr_fin) st_d = ST_FIN;
      ST_FIN:     st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      rc_own_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d == ST_PRE_HI) rc_own_q <= 1'b1;
    end
  end

  swb_ms_timer #(
    .CLK_PER_MS (CLK_PER_MS),
    .MS_W       (MS_W)
  ) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_ms (tmr_ms),
    .expire  (tmr_exp)
  );

  swb_pin_map #(
    .SK_STRAP (1'b1),
    .DI_STRAP (1'b0)
  ) pin_map_i (
    .state    (st_q),
    .rc_owned (rc_own_q),
    .pins     (pins)
  );

  assign wr_en = (st_q == ST_WRITES);

  swb_wr_issue #(
    .NUM (NUM_BOOT_WR)
  ) wr_issue_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (wr_en),
    .wr_list   (boot_list),
    .cmd_ready (cmd_ready),
    .wr_done   (wr_done),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .fin       (wr_fin)
  );

  assign busy  = (st_q != ST_IDLE);
  assign done  = (st_q == ST_FIN);
  assign rc_oe = pins.rc_oe;
  assign rc_o  = pins.rc_o;
  assign cs_oe = pins.cs_oe;
  assign cs_o  = pins.cs_o;
  assign sk_oe = pins.sk_oe;
  assign sk_o  = pins.sk_o;
  assign di_oe = pins.di_oe;
  assign di_o  = pins.di_o;
endmodule

// File: rtl/switch_boot_seq_chk.sv
module switch_boot_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        rc_oe,
  input logic        rc_o,
  input logic        cs_oe,
  input logic        sk_oe,
  input logic        sk_o,
  input logic        di_oe,
  input logic        di_o,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [7:0]  cmd_addr,
  input logic [15:0] cmd_data
);
  // R4
  strap_before_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_oe && rc_o && $past(rc_oe) && !$past(rc_o)) |->
      ($past(sk_oe) && $past(sk_o) && $past(di_oe) && !$past(di_o)));

  // R5
  cs_released_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs_oe);

  // R5
  rc_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rc_oe) && !$past(busy)) |-> (rc_oe && rc_o));

  // R6
  pins_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (!sk_oe && !di_oe));

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_data)));

  // R7
  cmd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
endmodule

bind switch_boot_seq switch_boot_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .rc_oe     (rc_oe),
  .rc_o      (rc_o),
  .cs_oe     (cs_oe),
  .sk_oe     (sk_oe),
  .sk_o      (sk_o),
  .di_oe     (di_oe),
  .di_o      (di_o),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_addr  (cmd_addr),
  .cmd_data  (cmd_data)
);

// File: tb/switch_boot_seq_tb.sv
module switch_boot_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MS_CYC     = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rst_pin_en = 1'b0;
  logic        busy, done;
  logic        rc_oe, rc_o, cs_oe, cs_o, sk_oe, sk_o, di_oe, di_o;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [7:0]  cmd_addr;
  logic [15:0] cmd_data;
  logic        wr_done = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_q[$];
  int  rdy_mode = 0;
  int  hs_count = 0;
  bit  stray_used = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  switch_boot_seq #(.CLK_PER_MS(MS_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rst_pin_en(rst_pin_en),
    .busy(busy), .done(done),
    .rc_oe(rc_oe), .rc_o(rc_o), .cs_oe(cs_oe), .cs_o(cs_o),
    .sk_oe(sk_oe), .sk_o(sk_o), .di_oe(di_oe), .di_o(di_o),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wr_done(wr_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push_boot_writes();
    exp_q.push_back({8'h09, 16'hBC1F});
    exp_q.push_back({8'h11, 16'hFF30});
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // register master model and scoreboard monitor
  initial begin
    int  cyc = 0;
    int  wait_cnt = -1;
    bit  pending = 0;
    bit  last_wr = 0;
    bit  expect_done = 0;
    bit  just_hs = 0;
    bit  held = 0;
    logic [23:0] held_item = '0;
    logic [23:0] exp_item;
    forever begin
      @(negedge clk);
      if (expect_done) begin
        check(done === 1'b1, "R9", "done after last wr_done", done, 1);
        expect_done = 0;
      end
      if (just_hs) begin
        check(cmd_valid === 1'b0, "R7", "valid after transfer", cmd_valid, 0);
        just_hs = 0;
      end
      if (held) begin
        check(cmd_valid === 1'b1 && {cmd_addr, cmd_data} === held_item, "R7",
              "held command", {cmd_valid, cmd_addr, cmd_data}, {1'b1, held_item});
        held = 0;
      end
      wr_done = 1'b0;
      if (pending && cmd_valid === 1'b1)
        check(0, "R8", "command offered before wr_done", 1, 0);
      if (pending && wait_cnt > 0) begin
        wait_cnt--;
        if (wait_cnt == 0) begin
          wr_done = 1'b1;
          pending = 0;
          if (last_wr) expect_done = 1;
        end
      end
      cyc++;
      cmd_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
      if (cmd_valid === 1'b1 && cmd_ready) begin
        hs_count++;
        if (exp_q.size() == 0) begin
          check(0, "R11", "unexpected write", {cmd_addr, cmd_data}, 0);
        end else begin
          exp_item = exp_q.pop_front();
          check({cmd_addr, cmd_data} === exp_item, "R6", "write addr/data",
                {cmd_addr, cmd_data}, exp_item);
          last_wr = (exp_q.size() == 0);
        end
        pending  = 1;
        just_hs  = 1;
        wait_cnt = (rdy_mode == 0) ? 1 : 4;
      end else if (cmd_valid === 1'b1) begin
        held      = 1;
        held_item = {cmd_addr, cmd_data};
        if (!stray_used && !pending) begin
          wr_done    = 1'b1; // R8: stray pulse during an offer
          stray_used = 1;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    int strap_cnt;
    bit bad;
    logic l_sk, l_dioe, l_di;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(busy === 0 && done === 0 && cmd_valid === 0, "R1", "status after reset",
          {busy, done, cmd_valid}, 0);
    check({rc_oe, cs_oe, sk_oe, di_oe} === 4'b0, "R1", "pin enables after reset",
          {rc_oe, cs_oe, sk_oe, di_oe}, 0);

    // Run without reset line, throttled master
    rdy_mode = 1;
    rst_pin_en = 1'b0;
    push_boot_writes();
    pulse_start();
    // R10
    check(cmd_valid === 1'b1 && busy === 1'b1, "R10", "first command right after start",
          {cmd_valid, busy}, 2'b11);
    bad = 0;
    cnt = 0;
    while (done !== 1'b1 && cnt < 2000) begin
      if (rc_oe !== 1'b0 || sk_oe !== 1'b0 || di_oe !== 1'b0) bad = 1;
      cnt++;
      if (cnt == 3) start = 1'b1; // R11: request during the writes
      if (cnt == 4) start = 1'b0;
      @(negedge clk);
    end
    check(!bad, "R10", "no pin driven without reset line", bad, 0);
    @(negedge clk);
    check(busy === 1'b0, "R9", "busy low after done", busy, 0);
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0 && hs_count == 2, "R11", "writes in no-pin run",
          hs_count, 2);
    check(busy === 1'b0 && cmd_valid === 1'b0, "R11", "no run from ignored start",
          {busy, cmd_valid}, 0);
    check(stray_used, "R8", "stray wr_done applied", stray_used, 1);

    // Run with reset line, free-running master
    rdy_mode = 0;
    rst_pin_en = 1'b1;
    push_boot_writes();
    pulse_start();
    check(rc_oe === 1'b1 && rc_o === 1'b1 && sk_oe === 1'b0, "R2", "line high after start",
          {rc_oe, rc_o, sk_oe}, 3'b110);
    cnt = 0;
    while (rc_o === 1'b1 && sk_oe === 1'b0) begin
      cnt++;
      if (cnt == 50) start = 1'b1; // R11: request during the waveform
      if (cnt == 51) start = 1'b0;
      @(negedge clk);
    end
    check(cnt == 20 * MS_CYC, "R2", "first high phase cycles", cnt, 20 * MS_CYC);
    cnt = 0;
    strap_cnt = 0;
    l_sk = 0; l_dioe = 0; l_di = 1;
    while (rc_o === 1'b0) begin
      cnt++;
      if (sk_oe === 1'b1) begin
        strap_cnt++;
        l_sk = sk_o; l_dioe = di_oe; l_di = di_o;
      end
      @(negedge clk);
    end
    check(cnt == 100 * MS_CYC + 1, "R3", "low phase cycles", cnt, 100 * MS_CYC + 1);
    check(strap_cnt == 1, "R4", "strap cycles while low", strap_cnt, 1);
    check(l_sk === 1'b1 && l_dioe === 1'b1 && l_di === 1'b0, "R4", "strap levels",
          {l_sk, l_dioe, l_di}, 3'b110);
    cnt = 0;
    bad = 0;
    while (sk_oe === 1'b1) begin
      cnt++;
      if (rc_o !== 1'b1 || sk_o !== 1'b1 || di_oe !== 1'b1 || di_o !== 1'b0) bad = 1;
      @(negedge clk);
    end
    check(cnt == 30 * MS_CYC, "R5", "final high phase cycles", cnt, 30 * MS_CYC);
    check(!bad, "R4", "straps held while high", bad, 0);
    check(rc_oe === 1'b1 && rc_o === 1'b1 && di_oe === 1'b0 && cs_oe === 1'b0, "R5",
          "pins released, line high", {rc_oe, rc_o, di_oe, cs_oe}, 4'b1100);
    cnt = 0;
    while (busy === 1'b1 && cnt < 2000) begin
      cnt++;
      @(negedge clk);
    end
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0 && hs_count == 4, "R6", "both boot writes done",
          hs_count, 4);
    check(rc_oe === 1'b1 && rc_o === 1'b1 && busy === 1'b0, "R5", "line kept high after run",
          {rc_oe, rc_o, busy}, 3'b110);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule